// File: doc/BRIEF.md
# Packed 4:2:2 Luma/Chroma to 10-bit RGB Converter

This block accepts a packed 4:2:2 luma/chroma byte stream, one byte per pixel-clock cycle, grouped in fours as blue-difference chroma, first luma, red-difference chroma, second luma. It forms two pixels per group, both using that group's chroma pair, and converts each pixel to 10-bit red, green and blue. The output goes to a downstream FIFO and is marked by a one-cycle valid strobe.

The colour matrix is evaluated in integer multiply-add form. The coefficients are pre-scaled by four and by 2^8, so 8-bit inputs land in a 10-bit output range. The result is rounded, shifted down and then saturated, so an out-of-range value sticks at 0 or 1023 instead of wrapping. A start-of-line input forces the byte that carries it to be taken as the first chroma byte of a group. This keeps the pairing aligned after a dropped or extra byte.

Top module: `ycc422_rgb_conv`

## Requirements
- R1: While reset is held and after its release with no input, out_valid is 0 and out_r, out_g, out_b are 0.
- R2: Accepted bytes cycle through the roles Cb, Y0, Cr, Y1. The Cr byte completes pixel (Y0, Cb, Cr) and the Y1 byte completes pixel (Y1, Cb, Cr), with both pixels using the same chroma pair.
- R3: With cb' = Cb-128 and cr' = Cr-128, each channel equals floor((S+128)/256) before saturation, where S for red is 1024*Y+1436*cr', for green is 1024*Y-352*cb'-731*cr', and for blue is 1024*Y+1815*cb'.
- R4: A cycle with in_valid low is ignored, including its in_data and in_sol. It neither advances the byte role nor produces a pixel.
- R5: A byte accepted with in_sol high is taken as Cb. Any partly collected group before it is discarded without producing a pixel.
- R6: out_valid is high for exactly one cycle per pixel, at the third rising edge counted from the edge that samples the completing byte. Pixels appear in input order.
- R7: A channel whose unsaturated value exceeds 1023 outputs 1023.
- R8: A channel whose unsaturated value is negative outputs 0.
- R9: With Cb = Cr = 128, all three channels equal exactly 4*Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | in_data carries a stream byte this cycle |
| in_data | input | 8 | Stream byte (Cb, Y0, Cr or Y1 by position) |
| in_sol | input | 1 | First byte of a line; forces the Cb role |
| out_valid | output | 1 | One-cycle strobe marking a converted pixel |
| out_r | output | 10 | Red, saturated to 0..1023 |
| out_g | output | 10 | Green, saturated to 0..1023 |
| out_b | output | 10 | Blue, saturated to 0..1023 |

## Verification
A byte-role counter that drifts shows up at the ports within one group. Luma and chroma are swapped, the colours are far off from the expected triplet, and the strobe falls on the Y0 or Cb byte instead of Cr and Y1. A stale chroma register corrupts only the second pixel of a group, so the bench varies chroma from group to group and checks both pixels. A pipeline stage that is skipped or doubled moves the strobe one cycle early or late, and the bench catches this on the first pixel by comparing against the cycle at which the strobe is expected.

// File: rtl/ycc_pkg.sv
package ycc_pkg;
    localparam int unsigned IN_W  = 8;
    localparam int unsigned OUT_W = 10;
    localparam int unsigned FRAC  = 8;
    localparam int unsigned ACC_W = 22;

    typedef struct packed {
        logic            vld;
        logic [IN_W-1:0] y;
        logic [IN_W-1:0] cb;
        logic [IN_W-1:0] cr;
    } pix_t;

    typedef struct packed {
        logic                    vld;
        logic signed [ACC_W-1:0] luma;
        logic signed [ACC_W-1:0] r_cr;
        logic signed [ACC_W-1:0] g_cb;
        logic signed [ACC_W-1:0] g_cr;
        logic signed [ACC_W-1:0] b_cb;
    } prod_t;

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] r;
        logic [OUT_W-1:0] g;
        logic [OUT_W-1:0] b;
    } rgb_t;
endpackage

// File: rtl/ycc_pair.sv
module ycc_pair
    import ycc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [IN_W-1:0] in_data,
    input  logic            in_sol,
    output pix_t            pix_o
);
    typedef struct packed {
        logic [1:0]      phase;
        logic [IN_W-1:0] cb;
        logic [IN_W-1:0] y0;
        logic [IN_W-1:0] cr;
        pix_t            out;
    } pair_st_t;

    pair_st_t st_d, st_q;
    logic [1:0] role;

    always_comb begin
        st_d         = st_q;
        st_d.out.vld = 1'b0;
        role         = in_sol ? 2'd0 : st_q.phase;
        if (in_valid) begin
            st_d.phase = role + 2'd1;
            case (role)
                2'd0: st_d.cb = in_data;
                2'd1: st_d.y0 = in_data;
                2'd2: begin
                    st_d.cr  = in_data;
                    st_d.out = '{vld: 1'b1, y: st_q.y0, cb: st_q.cb, cr: in_data};
                end
                default: st_d.out = '{vld: 1'b1, y: in_data, cb: st_q.cb, cr: st_q.cr};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pix_o = st_q.out;

    // R5: a start-of-line byte always takes the Cb role
    a_r5_sol_realign: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sol) |=> (st_q.phase == 2'd1 && !st_q.out.vld));
    // R4: a pixel never appears unless a byte was accepted
    a_r4_emit_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.out.vld |-> $past(in_valid));
    // R4: idle cycles leave the byte role untouched
    a_r4_idle_holds_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q.phase));
endmodule

// File: rtl/ycc_matrix.sv
module ycc_matrix
    import ycc_pkg::*;
#(
    parameter int K_Y  = 1024,
    parameter int K_RV = 1436,
    parameter int K_GU = 352,
    parameter int K_GV = 731,
    parameter int K_BU = 1815
) (
    input  logic  clk,
    input  logic  rst_n,
    input  pix_t  pix_i,
    output prod_t prod_o
);
    localparam logic signed [ACC_W-1:0] C_Y   = ACC_W'(K_Y);
    localparam logic signed [ACC_W-1:0] C_RV  = ACC_W'(K_RV);
    localparam logic signed [ACC_W-1:0] C_GU  = ACC_W'(K_GU);
    localparam logic signed [ACC_W-1:0] C_GV  = ACC_W'(K_GV);
    localparam logic signed [ACC_W-1:0] C_BU  = ACC_W'(K_BU);
    localparam logic signed [ACC_W-1:0] CBIAS = ACC_W'(1 << (IN_W - 1));

    prod_t prod_d, prod_q;
    logic signed [ACC_W-1:0] y_s, cb_s, cr_s;

    always_comb begin
        y_s  = $signed({{(ACC_W-IN_W){1'b0}}, pix_i.y});
        cb_s = $signed({{(ACC_W-IN_W){1'b0}}, pix_i.cb}) - CBIAS;
        cr_s = $signed({{(ACC_W-IN_W){1'b0}}, pix_i.cr}) - CBIAS;
        prod_d.vld  = pix_i.vld;
        prod_d.luma = y_s  * C_Y;
        prod_d.r_cr = cr_s * C_RV;
        prod_d.g_cb = cb_s * C_GU;
        prod_d.g_cr = cr_s * C_GV;
        prod_d.b_cb = cb_s * C_BU;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prod_q <= '0;
        else        prod_q <= prod_d;
    end

    assign prod_o = prod_q;

    // R6: each pixel moves on to the product stage exactly one cycle later
    a_r6_stage_step: assert property (@(posedge clk) disable iff (!rst_n)
        pix_i.vld |=> prod_q.vld);
endmodule

// File: rtl/ycc_clamp.sv
module ycc_clamp
    import ycc_pkg::*;
(
    input  logic signed [ACC_W-1:0] acc_i,
    output logic [OUT_W-1:0]        val_o
);
    localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1 << (FRAC - 1));
    localparam logic signed [ACC_W-1:0] OMAX = ACC_W'((1 << OUT_W) - 1);

    logic signed [ACC_W-1:0] shifted;

    always_comb begin
        shifted = (acc_i + RND) >>> FRAC;
        if (shifted < 0)         val_o = '0;
        else if (shifted > OMAX) val_o = OMAX[OUT_W-1:0];
        else                     val_o = shifted[OUT_W-1:0];
    end
endmodule

// File: rtl/ycc422_rgb_conv.sv
module ycc422_rgb_conv
    import ycc_pkg::*;
#(
    parameter int K_Y  = 1024,
    parameter int K_RV = 1436,
    parameter int K_GU = 352,
    parameter int K_GV = 731,
    parameter int K_BU = 1815
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    input  logic             in_sol,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_r,
    output logic [OUT_W-1:0] out_g,
    output logic [OUT_W-1:0] out_b
);
    localparam int NCH = 3;

    pix_t  pix;
    prod_t prod;
    rgb_t  rgb_d, rgb_q;
    logic signed [ACC_W-1:0] sum   [NCH];
    logic [OUT_W-1:0]        chan  [NCH];

    ycc_pair u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_sol   (in_sol),
        .pix_o    (pix)
    );

    ycc_matrix #(
        .K_Y (K_Y), .K_RV (K_RV), .K_GU (K_GU), .K_GV (K_GV), .K_BU (K_BU)
    ) u_matrix (
        .clk    (clk),
        .rst_n  (rst_n),
        .pix_i  (pix),
        .prod_o (prod)
    );

    always_comb begin
        sum[0] = prod.luma + prod.r_cr;
        sum[1] = prod.luma - prod.g_cb - prod.g_cr;
        sum[2] = prod.luma + prod.b_cb;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        ycc_clamp u_clamp (
            .acc_i (sum[ch]),
            .val_o (chan[ch])
        );
    end

    always_comb begin
        rgb_d     = rgb_q;
        rgb_d.vld = prod.vld;
        if (prod.vld) begin
            rgb_d.r = chan[0];
            rgb_d.g = chan[1];
            rgb_d.b = chan[2];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rgb_q <= '0;
        else        rgb_q <= rgb_d;
    end

    assign out_valid = rgb_q.vld;
    assign out_r     = rgb_q.r;
    assign out_g     = rgb_q.g;
    assign out_b     = rgb_q.b;

    // R6: a paired pixel reaches the outputs two edges after leaving pairing
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        pix.vld |-> ##2 out_valid);
    // R6: no strobe without a paired pixel two edges earlier
    a_r6_no_extra: assert property (@(posedge clk) disable iff (!rst_n)
        !pix.vld |-> ##2 !out_valid);
    // R4: a strobe always traces back to an accepted byte three edges earlier
    a_r4_strobe_origin: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3));
    // R1: outputs hold between pixels
    a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(prod.vld) |-> $stable(out_r));
endmodule

// File: tb/ycc422_rgb_conv_bench.sv
module ycc422_rgb_conv_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_sol = 1'b0;
    logic       out_valid;
    logic [9:0] out_r, out_g, out_b;

    ycc422_rgb_conv u_ycc422_rgb_conv (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_data (in_data),
        .in_sol (in_sol), .out_valid (out_valid), .out_r (out_r),
        .out_g (out_g), .out_b (out_b)
    );

    typedef struct {
        int stamp;
        int r;
        int g;
        int b;
    } exp_t;

    exp_t  expq[$];
    string cur_req = "R1";
    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    int    m_phase = 0;
    int    m_cb = 0, m_y0 = 0, m_cr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sat(int s);
        int v;
        v = (s + 128) >>> 8;
        if (v < 0) return 0;
        if (v > 1023) return 1023;
        return v;
    endfunction

    function automatic exp_t model(int y, int cb, int cr, int stamp);
        exp_t e;
        int   u, v;
        u = cb - 128;
        v = cr - 128;
        e.stamp = stamp;
        e.r = sat(1024*y + 1436*v);
        e.g = sat(1024*y - 352*u - 731*v);
        e.b = sat(1024*y + 1815*u);
        return e;
    endfunction

    // Scoreboard: every strobe is matched to the next expected pixel.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (expq.size() == 0) begin
                chk(cur_req, "unexpected strobe", 1, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk(cur_req, "strobe cycle (R6)", cyc, e.stamp);
                chk(cur_req, "red", int'(out_r), e.r);
                chk(cur_req, "green", int'(out_g), e.g);
                chk(cur_req, "blue", int'(out_b), e.b);
            end
        end
    end

    task automatic send(int d, bit sol);
        int role;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d[7:0];
        in_sol   = sol;
        role     = sol ? 0 : m_phase;
        m_phase  = (role + 1) % 4;
        case (role)
            0: m_cb = d;
            1: m_y0 = d;
            2: begin
                m_cr = d;
                expq.push_back(model(m_y0, m_cb, m_cr, cyc + 3));
            end
            default: expq.push_back(model(d, m_cb, m_cr, cyc + 3));
        endcase
    endtask

    task automatic idle(int n, int d, bit sol);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = d[7:0];
            in_sol   = sol;
        end
    endtask

    task automatic group(int cb, int y0, int cr, int y1, bit sol);
        send(cb, sol);
        send(y0, 1'b0);
        send(cr, 1'b0);
        send(y1, 1'b0);
    endtask

    task automatic drain(string req);
        idle(6, 0, 1'b0);
        chk(req, "pixels left undelivered", expq.size(), 0);
    endtask

    task automatic t_reset();
        cur_req = "R1";
        repeat (3) @(negedge clk);
        chk("R1", "out_valid in reset", int'(out_valid), 0);
        chk("R1", "out_r in reset", int'(out_r), 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1", "out_valid idle", int'(out_valid), 0);
        chk("R1", "out_g idle", int'(out_g), 0);
        chk("R1", "out_b idle", int'(out_b), 0);
    endtask

    task automatic t_gray();
        cur_req = "R9";
        group(128, 0, 128, 255, 1'b1);
        group(128, 16, 128, 235, 1'b0);
        group(128, 100, 128, 101, 1'b0);
        drain("R9");
        chk("R9", "gray Y=101 gives 4*Y on red", int'(out_r), 404);
        chk("R9", "gray Y=101 gives 4*Y on blue", int'(out_b), 404);
    endtask

    task automatic t_colors();
        cur_req = "R2/R3/R6";
        group(90, 120, 200, 60, 1'b1);
        group(200, 80, 60, 180, 1'b0);
        group(110, 150, 140, 30, 1'b0);
        group(160, 70, 100, 210, 1'b0);
        drain("R2");
    endtask

    task automatic t_sat_high();
        cur_req = "R7";
        group(128, 255, 255, 250, 1'b1);
        group(255, 255, 128, 240, 1'b0);
        drain("R7");
        chk("R7", "blue stuck at full scale", int'(out_b), 1023);
    endtask

    task automatic t_sat_low();
        cur_req = "R8";
        group(128, 0, 0, 10, 1'b1);
        group(0, 5, 128, 0, 1'b0);
        drain("R8");
        chk("R8", "blue floored at zero", int'(out_b), 0);
    endtask

    task automatic t_gaps();
        cur_req = "R4";
        send(70, 1'b1);
        idle(2, 255, 1'b1);
        send(130, 1'b0);
        idle(1, 9, 1'b1);
        send(190, 1'b0);
        idle(3, 0, 1'b1);
        send(40, 1'b0);
        drain("R4");
    endtask

    task automatic t_realign();
        cur_req = "R5";
        send(30, 1'b1);
        send(220, 1'b0);
        group(200, 90, 40, 170, 1'b1);
        send(60, 1'b0);
        send(100, 1'b0);
        send(50, 1'b0);
        group(40, 200, 210, 20, 1'b1);
        drain("R5");
    endtask

    task automatic t_backtoback();
        cur_req = "R6";
        for (int k = 0; k < 8; k++)
            group(16 + 29*k, 235 - 25*k, 240 - 27*k, 10 + 30*k, k == 0);
        drain("R6");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_gray();
        t_colors();
        t_sat_high();
        t_sat_low();
        t_gaps();
        t_realign();
        t_backtoback();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule